// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block turns one input clock into two banks of divided clocks. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter or one sixth of it. Each bank's ratio is chosen by its own select pin. Both banks come from a single modulo-12 phase counter, so every output rises on the same input edge at the start of each 12-cycle frame. Each output has a 50% duty cycle.

A freeze input is sampled on the falling input-clock edge. While it is captured high, the counter stops at the first phase where every output is low, and the outputs stay low until the freeze is released. A new select value takes effect only at a frame boundary. Together these rules mean that no output high phase is ever cut short. An asynchronous master reset forces every output low at once. Its release is synchronised to the input clock, so several instances released together produce identical output sequences. With every control input tied low, the block runs at divide by 2 and divide by 4.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: Bank A divides the input by 2 when `sel_a` is 0 and by 4 when `sel_a` is 1, with a high time of half the period.
- R2: Bank B divides the input by 4 when `sel_b` is 0 and by 6 when `sel_b` is 1, with a high time of half the period.
- R3: After reset release, the outputs stay low through the first rising input edge and all rise on the second. From then on, every output rises at each 12-cycle frame start, and every bank B rising edge coincides with a bank A rising edge except in the divide-by-4 / divide-by-6 pairing.
- R4: While `mreset` is 1, every output is 0 immediately, whatever the clock and `hold` are doing.
- R5: `hold` is captured on the falling input edge. Once a captured 1 is seen, the counter stops at the first phase where all outputs are low, and the outputs stay low until `hold` is captured as 0. Counting then resumes.
- R6: No output high phase is ever shorter or longer than half its period, and no low phase is ever shorter than half its period, under any pattern of `hold` toggling.
- R7: A change on `sel_a` or `sel_b` takes effect only on the input edge that starts a new 12-cycle frame.
- R8: All outputs within a bank carry the same waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; the dividers advance on its rising edge |
| mreset | input | 1 | Asynchronous master reset, active high, released synchronously |
| hold | input | 1 | Freeze request, active high, sampled on the falling edge |
| sel_a | input | 1 | Bank A ratio select: 0 = divide by 2, 1 = divide by 4 |
| sel_b | input | 1 | Bank B ratio select: 0 = divide by 4, 1 = divide by 6 |
| out_a | output | N_OUT_A | Bank A divided clock outputs |
| out_b | output | N_OUT_B | Bank B divided clock outputs |

## Verification
The hardest situation to reach from the ports is a freeze request that arrives while an output is high, or one that toggles faster than the slowest output's half period. In either case the stop has to be deferred to a phase where every output is low. The stimulus toggles `hold` on every input cycle and then on every third cycle, in both the fastest and the slowest ratio pairings. A monitor meanwhile measures every high and low stretch and every bank B rising edge. Select changes are placed both mid-frame and in the last cycle before a frame boundary, so that their effect at exactly the frame boundary is visible.

// File: rtl/dualdiv_pkg.sv
package dualdiv_pkg;

  typedef struct packed {
    logic b;
    logic a;
  } sel_pair_t;

  // Level of a 50% duty divided clock at a given phase of the shared counter.
  function automatic logic phase_is_high(input int unsigned phase, input int unsigned ratio);
    return (phase % ratio) < (ratio / 2);
  endfunction

endpackage

// File: rtl/ddiv_reset_release.sv
module ddiv_reset_release (
  input  logic clk,
  input  logic mreset,
  output logic run_ok
);

  logic run_d;

  always_comb begin
    run_d = 1'b1;
  end

  always_ff @(posedge clk or posedge mreset) begin
    if (mreset) run_ok <= 1'b0;
    else        run_ok <= run_d;
  end

endmodule

// File: rtl/ddiv_hold_sampler.sv
module ddiv_hold_sampler (
  input  logic clk,
  input  logic mreset,
  input  logic hold,
  output logic hold_q
);

  always_ff @(negedge clk or posedge mreset) begin
    if (mreset) hold_q <= 1'b0;
    else        hold_q <= hold;
  end

endmodule

// File: rtl/ddiv_phase_core.sv
module ddiv_phase_core
  import dualdiv_pkg::*;
#(
  parameter int unsigned RATIO_A_LO = 2,
  parameter int unsigned RATIO_A_HI = 4,
  parameter int unsigned RATIO_B_LO = 4,
  parameter int unsigned RATIO_B_HI = 6,
  parameter int unsigned PHASES     = 12,
  parameter int unsigned CW         = 4
) (
  input  logic          clk,
  input  logic          mreset,
  input  logic          run_ok,
  input  logic          hold_q,
  input  sel_pair_t     sel_pins,
  output logic [CW-1:0] cnt_q,
  output sel_pair_t     sel_q,
  output logic          lvl_a,
  output logic          lvl_b
);

  localparam logic [CW-1:0] LAST_PHASE = CW'(PHASES - 1);

  logic [CW-1:0] cnt_d;
  sel_pair_t     sel_d;
  logic          stall_q, stall_d;
  logic          lvl_a_d, lvl_b_d;
  logic          safe, wrap, adv;
  int unsigned   ra_now, rb_now, ra_nxt, rb_nxt;

  always_comb begin
    ra_now = sel_q.a ? RATIO_A_HI : RATIO_A_LO;
    rb_now = sel_q.b ? RATIO_B_HI : RATIO_B_LO;
    // All outputs are low at the current phase: stopping here cuts no pulse.
    safe = !phase_is_high(32'(cnt_q), ra_now) && !phase_is_high(32'(cnt_q), rb_now);

    if (!run_ok)      stall_d = 1'b0;
    else if (stall_q) stall_d = hold_q;
    else              stall_d = hold_q && safe;

    adv  = run_ok && !stall_d;
    wrap = (cnt_q == LAST_PHASE);

    cnt_d = cnt_q;
    sel_d = sel_q;
    if (adv) begin
      if (wrap) begin
        cnt_d = '0;
        sel_d = sel_pins;   // ratios change only at a frame boundary
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end

    ra_nxt  = sel_d.a ? RATIO_A_HI : RATIO_A_LO;
    rb_nxt  = sel_d.b ? RATIO_B_HI : RATIO_B_LO;
    lvl_a_d = phase_is_high(32'(cnt_d), ra_nxt);
    lvl_b_d = phase_is_high(32'(cnt_d), rb_nxt);
  end

  always_ff @(posedge clk or posedge mreset) begin
    if (mreset) begin
      cnt_q   <= LAST_PHASE;
      sel_q   <= '0;
      stall_q <= 1'b0;
      lvl_a   <= 1'b0;
      lvl_b   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
      stall_q <= stall_d;
      lvl_a   <= lvl_a_d;
      lvl_b   <= lvl_b_d;
    end
  end

endmodule

// File: rtl/ddiv_bank_fanout.sv
module ddiv_bank_fanout #(
  parameter int unsigned N = 2
) (
  input  logic         lvl,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_copy
    assign q[i] = lvl;
  end

endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv
  import dualdiv_pkg::*;
#(
  parameter int unsigned RATIO_A_LO = 2,
  parameter int unsigned RATIO_A_HI = 4,
  parameter int unsigned RATIO_B_LO = 4,
  parameter int unsigned RATIO_B_HI = 6,
  parameter int unsigned PHASES     = 12,
  parameter int unsigned N_OUT_A    = 2,
  parameter int unsigned N_OUT_B    = 2
) (
  input  logic               clk_in,
  input  logic               mreset,
  input  logic               hold,
  input  logic               sel_a,
  input  logic               sel_b,
  output logic [N_OUT_A-1:0] out_a,
  output logic [N_OUT_B-1:0] out_b
);

  localparam int unsigned CW = $clog2(PHASES);

  logic          run_ok;
  logic          hold_q;
  logic [CW-1:0] cnt_q;
  sel_pair_t     sel_pins, sel_q;
  logic          sel_a_q, sel_b_q;
  logic          lvl_a, lvl_b;

  assign sel_pins.a = sel_a;
  assign sel_pins.b = sel_b;
  assign sel_a_q    = sel_q.a;
  assign sel_b_q    = sel_q.b;

  ddiv_reset_release i_release (
    .clk    (clk_in),
    .mreset (mreset),
    .run_ok (run_ok)
  );

  ddiv_hold_sampler i_hold (
    .clk    (clk_in),
    .mreset (mreset),
    .hold   (hold),
    .hold_q (hold_q)
  );

  ddiv_phase_core #(
    .RATIO_A_LO (RATIO_A_LO),
    .RATIO_A_HI (RATIO_A_HI),
    .RATIO_B_LO (RATIO_B_LO),
    .RATIO_B_HI (RATIO_B_HI),
    .PHASES     (PHASES),
    .CW         (CW)
  ) i_core (
    .clk      (clk_in),
    .mreset   (mreset),
    .run_ok   (run_ok),
    .hold_q   (hold_q),
    .sel_pins (sel_pins),
    .cnt_q    (cnt_q),
    .sel_q    (sel_q),
    .lvl_a    (lvl_a),
    .lvl_b    (lvl_b)
  );

  ddiv_bank_fanout #(.N(N_OUT_A)) i_bank_a (.lvl(lvl_a), .q(out_a));
  ddiv_bank_fanout #(.N(N_OUT_B)) i_bank_b (.lvl(lvl_b), .q(out_b));

endmodule

// File: rtl/ddiv_checker.sv
module ddiv_checker #(
  parameter int unsigned NA = 2,
  parameter int unsigned NB = 2,
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          mreset,
  input logic          hold_q,
  input logic          sel_a_q,
  input logic          sel_b_q,
  input logic [CW-1:0] cnt_q,
  input logic [NA-1:0] out_a,
  input logic [NB-1:0] out_b
);

  logic all_low;
  assign all_low = (out_a == '0) && (out_b == '0);

  // R4: reset holds every output low
  p_reset_low_r4: assert property (@(posedge clk) mreset |-> all_low);

  // R5: a captured freeze at an all-low phase keeps the outputs still
  p_freeze_still_r5: assert property (@(posedge clk) disable iff (mreset)
    (hold_q && all_low) |=> ($stable(out_a) && $stable(out_b)));

  // R7: the active ratio changes only when the frame restarts
  p_sel_at_frame_r7: assert property (@(posedge clk) disable iff (mreset)
    !($stable(sel_a_q) && $stable(sel_b_q)) |-> (cnt_q == '0));

  // R3: a bank B rise without a bank A rise only in the 4/6 pairing
  p_rise_align_r3: assert property (@(posedge clk) disable iff (mreset)
    ($rose(out_b[0]) && !$rose(out_a[0])) |-> (sel_a_q && sel_b_q));

  // R1: divide-by-2 high phase lasts exactly one input cycle
  p_half_a_r1: assert property (@(posedge clk) disable iff (mreset)
    ($rose(out_a[0]) && !sel_a_q) |=> !out_a[0]);

  // R2: divide-by-4 high phase lasts at least two input cycles
  p_half_b_r2: assert property (@(posedge clk) disable iff (mreset)
    ($rose(out_b[0]) && !sel_b_q) |=> out_b[0]);

endmodule

bind dual_ratio_clkdiv ddiv_checker #(
  .NA (N_OUT_A),
  .NB (N_OUT_B),
  .CW (CW)
) i_chk (
  .clk     (clk_in),
  .mreset  (mreset),
  .hold_q  (hold_q),
  .sel_a_q (sel_a_q),
  .sel_b_q (sel_b_q),
  .cnt_q   (cnt_q),
  .out_a   (out_a),
  .out_b   (out_b)
);

// File: tb/test_dual_ratio_clkdiv.sv
module test_dual_ratio_clkdiv;

  localparam int NA = 2;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          mreset = 1'b1;
  logic          hold = 1'b0;
  logic          sel_a = 1'b0;
  logic          sel_b = 1'b0;
  logic [NA-1:0] out_a;
  logic [NB-1:0] out_b;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit mon_on = 0;
  int cur_ra = 2;
  int cur_rb = 4;

  always #5 clk = ~clk;

  dual_ratio_clkdiv #(.N_OUT_A(NA), .N_OUT_B(NB)) i_dual_ratio_clkdiv (
    .clk_in (clk),
    .mreset (mreset),
    .hold   (hold),
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .out_a  (out_a),
    .out_b  (out_b)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit lvl(input int k, input int r);
    return ((k % 12) % r) < (r / 2);
  endfunction

  // Stretch and edge monitor (R6, R3, R8)
  logic pa, pb;
  int   run_a, run_b;
  bit   known_a, known_b;
  always @(negedge clk) begin
    if (!mon_on) begin
      pa = out_a[0]; pb = out_b[0];
      run_a = 0; run_b = 0; known_a = 0; known_b = 0;
    end else begin
      chk(out_a == {NA{out_a[0]}} && out_b == {NB{out_b[0]}}, "R8 bank copies",
          int'({out_a, out_b}), 0);
      if (out_b[0] && !pb && !(cur_ra == 4 && cur_rb == 6))
        chk(out_a[0] && !pa, "R3 bank B rise without bank A rise", int'(out_a[0]), 1);
      if (out_a[0] != pa) begin
        if (known_a) begin
          if (pa) chk(run_a == cur_ra / 2, "R6 bank A high stretch", run_a, cur_ra / 2);
          else    chk(run_a >= cur_ra / 2, "R6 bank A low stretch", run_a, cur_ra / 2);
        end
        known_a = 1; run_a = 1;
      end else run_a++;
      if (out_b[0] != pb) begin
        if (known_b) begin
          if (pb) chk(run_b == cur_rb / 2, "R6 bank B high stretch", run_b, cur_rb / 2);
          else    chk(run_b >= cur_rb / 2, "R6 bank B low stretch", run_b, cur_rb / 2);
        end
        known_b = 1; run_b = 1;
      end else run_b++;
      pa = out_a[0]; pb = out_b[0];
    end
  end

  task automatic do_reset(input bit sa, input bit sb);
    @(posedge clk); #1;
    mreset = 1'b1; hold = 1'b0; sel_a = sa; sel_b = sb;
    @(negedge clk);
    chk(out_a == '0 && out_b == '0, "R4 outputs low in reset", int'({out_a, out_b}), 0);
    @(posedge clk); #1;
    mreset = 1'b0;
    @(negedge clk);
    chk(out_a == '0 && out_b == '0, "R3 low before first edge", int'({out_a, out_b}), 0);
    @(negedge clk);
    chk(out_a == '0 && out_b == '0, "R3 low after first edge", int'({out_a, out_b}), 0);
  endtask

  task automatic hold_seq(input bit sa, input bit sb);
    bit seen;
    do_reset(sa, sb);
    cur_ra = sa ? 4 : 2;
    cur_rb = sb ? 6 : 4;
    mon_on = 1;
    repeat (7) @(posedge clk);
    #1 hold = 1'b1;
    repeat (12) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk(out_a == '0 && out_b == '0, "R5 frozen low while held", int'({out_a, out_b}), 0);
    end
    @(posedge clk); #1 hold = 1'b0;
    seen = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (out_a[0] && out_b[0]) seen = 1;
    end
    chk(seen, "R5 counting resumes after release", int'(seen), 1);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1 hold = ~hold;
    end
    for (int i = 0; i < 45; i++) begin
      @(posedge clk); #1 hold = (i % 3 == 0);
    end
    @(posedge clk); #1 hold = 1'b0;
    repeat (24) @(posedge clk);
    @(negedge clk);
    mon_on = 0;
  endtask

  initial begin
    int ra, rb, fa, fb;
    bit seen;
    repeat (3) @(posedge clk);

    // R1 / R2 / R3: every ratio pairing from reset
    for (int s = 0; s < 4; s++) begin
      do_reset(s[0], s[1]);
      ra = s[0] ? 4 : 2;
      rb = s[1] ? 6 : 4;
      for (int k = 0; k < 36; k++) begin
        @(negedge clk);
        chk(out_a[0] == lvl(k, ra), "R1 bank A level", int'(out_a[0]), int'(lvl(k, ra)));
        chk(out_b[0] == lvl(k, rb), "R2 bank B level", int'(out_b[0]), int'(lvl(k, rb)));
        if (k % 12 == 0)
          chk(out_a[0] && out_b[0], "R3 both high at frame start", int'({out_a[0], out_b[0]}), 3);
      end
    end

    // R7: select changes mid-frame and just before a frame boundary
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      case (k / 12)
        0:       begin fa = 2; fb = 4; end
        1:       begin fa = 4; fb = 6; end
        default: begin fa = 2; fb = 6; end
      endcase
      chk(out_a[0] == lvl(k, fa), "R7 bank A after select change", int'(out_a[0]), int'(lvl(k, fa)));
      chk(out_b[0] == lvl(k, fb), "R7 bank B after select change", int'(out_b[0]), int'(lvl(k, fb)));
      if (k == 5)  begin sel_a = 1'b1; sel_b = 1'b1; end
      if (k == 23) begin sel_a = 1'b0; sel_b = 1'b1; end
    end

    // R5 / R6: freeze and fast toggles in fastest and slowest pairings
    hold_seq(1'b0, 1'b0);
    hold_seq(1'b1, 1'b1);
    hold_seq(1'b0, 1'b1);

    // R4: asynchronous reset while an output is high, with hold asserted
    do_reset(1'b1, 1'b0);
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (out_a[0]) seen = 1;
    end
    chk(seen, "R4 output high before reset", int'(seen), 1);
    #2 mreset = 1'b1; hold = 1'b1;
    #1 chk(out_a == '0 && out_b == '0, "R4 immediate low on reset", int'({out_a, out_b}), 0);
    repeat (3) @(negedge clk);
    chk(out_a == '0 && out_b == '0, "R4 low held through edges", int'({out_a, out_b}), 0);
    hold = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule